// File: doc/BRIEF.md
# Count-up Watchdog Timer Pair

Two independent watchdog channels share one block. Each has a 32-bit register on a simple register bus. A channel's counter advances once per timebase tick and climbs toward a terminal value that software sets. A parameterised prescaler derives the tick from the system clock; with the default parameters one tick is 10 ms. Any write to a channel's register loads new settings and restarts the channel from zero. Software services the watchdog by rewriting the register before the count reaches the terminal value.

When a channel's count reaches a nonzero terminal value, the channel expires. It stays expired until its register is written again. On channel 0, expiry requests a system reset if the control bit is set. On channel 1, expiry asserts a traffic-block output if the control bit is set. The fabric uses that output to drop CPU-bound packets and turn off flow control on every port.

Top module: `wdog_pair`

## Requirements
- R1: After reset, both registers read zero and both action outputs are low.
- R2: Channel 0 sits at byte address 0xC0 and channel 1 at 0xC4. A read returns bit 31 = control bit, bits 30:16 = terminal value, bit 15 = 0, and bits 14:0 = current count.
- R3: The count advances by one every CLK_HZ/TICK_HZ clock cycles. The first increment lands that many cycles after the write that cleared it.
- R4: A write to a channel register stores bits 31 and 30:16 and clears that channel's count and prescaler. It also clears the channel's expired state. Bits 15:0 of the written data are ignored.
- R5: With a nonzero terminal value, the count stops at the terminal value and the channel is expired while count equals terminal.
- R6: sys_reset_req is high exactly while channel 0 is expired and its control bit is 1.
- R7: cpu_traffic_block is high exactly while channel 1 is expired and its control bit is 1.
- R8: A terminal value of zero never expires the channel. The count keeps advancing.
- R9: Accesses to any other address have no effect on either channel, and reads of them return zero. Reads of channel registers do not disturb the channels.
- R10: A write to one channel leaves the other channel's count and outputs untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read strobe |
| sys_reset_req | output | 1 | Channel 0 expiry action |
| cpu_traffic_block | output | 1 | Channel 1 expiry action |

## Verification
The bench sets CLK_HZ=400 and TICK_HZ=100, which gives a four-cycle tick. At that tick length, every count from zero to several terminal values can be read back on every cycle. For terminal values 1 through 5 on both channels, the bench compares each sample of count and action output against floor(cycles/4), capped at the terminal value. The short tick also brings within reach mid-count service writes, a control bit of zero, a terminal value of zero, unmapped accesses and cross-channel isolation, all within a few hundred cycles.

// File: rtl/wdog_pair.sv
module wdog_pair #(
  parameter int CLK_HZ = 50_000_000,
  parameter int TICK_HZ = 100,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CH0_ADDR = 8'hC0,
  parameter logic [ADDR_W-1:0] CH1_ADDR = 8'hC4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_reset_req,
  output logic              cpu_traffic_block
);
  localparam int DIV = (CLK_HZ / TICK_HZ) < 1 ? 1 : CLK_HZ / TICK_HZ;
  localparam int PW = DIV > 1 ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(DIV - 1);

  logic [1:0]  ctl, sel, wsel, hit;
  logic [14:0] term [2];
  logic [14:0] cnt  [2];
  logic [PW-1:0] pre [2];

  assign sel[0] = bus_addr == CH0_ADDR;
  assign sel[1] = bus_addr == CH1_ADDR;
  assign wsel   = (bus_en && bus_wr) ? sel : 2'b00;

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        ctl[i]  <= 1'b0;
        term[i] <= '0;
        cnt[i]  <= '0;
        pre[i]  <= '0;
      end else if (wsel[i]) begin
        ctl[i]  <= bus_wdata[31];
        term[i] <= bus_wdata[30:16];
        cnt[i]  <= '0;
        pre[i]  <= '0;
      end else if (pre[i] == PMAX) begin
        pre[i] <= '0;
        if (!hit[i]) cnt[i] <= cnt[i] + 15'd1;
      end else begin
        pre[i] <= pre[i] + 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 2; i++) hit[i] = (term[i] != '0) && (cnt[i] == term[i]);
  end

  assign sys_reset_req     = hit[0] & ctl[0];
  assign cpu_traffic_block = hit[1] & ctl[1];

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_wr) begin
      if (sel[0]) bus_rdata = {ctl[0], term[0], 1'b0, cnt[0]};
      if (sel[1]) bus_rdata = {ctl[1], term[1], 1'b0, cnt[1]};
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chk
    // R5: count never passes a nonzero terminal value
    a_r5_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
      (term[g] != '0) |-> (cnt[g] <= term[g]));
    // R4: write clears the count
    a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wsel[g] |=> (cnt[g] == '0));
    // R3: without a write the count holds or steps by one
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      !wsel[g] |=> (cnt[g] == $past(cnt[g]) || cnt[g] == $past(cnt[g]) + 15'd1));
  end

  // R6/R7: an action needs its control bit
  a_r6_reset_needs_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> ctl[0]);
  a_r7_block_needs_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_traffic_block |-> ctl[1]);
  // R2: reserved bit reads zero
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[15] == 1'b0);
endmodule

// File: tb/tb_wdog_pair.sv
module tb_wdog_pair;
  logic clk = 0, rst_n = 0, bus_en = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sys_reset_req, cpu_traffic_block;
  int checks = 0, fails = 0;
  localparam int DIV = 4;

  always #4 clk = ~clk;

  wdog_pair #(.CLK_HZ(400), .TICK_HZ(100)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_en = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  function automatic logic act_of(int c);
    return c == 0 ? sys_reset_req : cpu_traffic_block;
  endfunction

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rd(8'hC0, d); chk("R1 ch0 reset", d, 0);
    rd(8'hC4, d); chk("R1 ch1 reset", d, 0);
    chk("R1 outputs", {sys_reset_req, cpu_traffic_block}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int c = 0; c < 2; c++) begin
      for (int t = 1; t <= 5; t++) begin
        logic [7:0] a;
        a = c == 0 ? 8'hC0 : 8'hC4;
        wr(a, {1'b1, 15'(t), 1'b1, 15'h7FFF});
        for (int n = 0; n <= 4 * t + 5; n++) begin
          int ec;
          ec = (n / DIV) < t ? n / DIV : t;
          rd(a, d);
          chk("R2 R3 R4 R5 readback", d, {1'b1, 15'(t), 1'b0, 15'(ec)});
          chk(c == 0 ? "R6 reset action" : "R7 block action",
              32'(act_of(c)), 32'(n >= DIV * t));
          chk("R10 other channel quiet", 32'(act_of(1 - c)), 0);
          @(negedge clk);
        end
      end
      wr(c == 0 ? 8'hC0 : 8'hC4, 0);
    end

    // R4: service write mid-count and after expiry
    wr(8'hC0, {1'b1, 15'd3, 16'h0});
    repeat (10) @(negedge clk);
    rd(8'hC0, d); chk("R4 before service", d[14:0], 2);
    wr(8'hC0, {1'b1, 15'd3, 16'h0});
    rd(8'hC0, d); chk("R4 cleared", d[14:0], 0);
    repeat (4) @(negedge clk);
    rd(8'hC0, d); chk("R3 first tick after service", d[14:0], 1);
    repeat (12) @(negedge clk);
    chk("R6 expired", 32'(sys_reset_req), 1);
    wr(8'hC0, {1'b1, 15'd3, 16'h0});
    chk("R4 expiry cleared", 32'(sys_reset_req), 0);

    // R6/R7: control bit clear
    wr(8'hC0, {1'b0, 15'd2, 16'h0});
    wr(8'hC4, {1'b0, 15'd2, 16'h0});
    repeat (12) @(negedge clk);
    rd(8'hC0, d); chk("R5 saturate ctl0", d, {1'b0, 15'd2, 16'd2});
    chk("R6 no reset ctl=0", 32'(sys_reset_req), 0);
    chk("R7 no block ctl=0", 32'(cpu_traffic_block), 0);

    // R8: terminal zero
    wr(8'hC4, {1'b1, 15'd0, 16'h0});
    repeat (40) @(negedge clk);
    rd(8'hC4, d); chk("R8 free count", d, {1'b1, 15'd0, 16'd10});
    chk("R8 never expires", 32'(cpu_traffic_block), 0);

    // R9 / R10
    wr(8'hC0, {1'b1, 15'd20, 16'h0});
    repeat (7) @(negedge clk);
    wr(8'hC8, 32'hFFFF_FFFF);
    wr(8'h00, 32'h0000_0000);
    wr(8'hC4, {1'b1, 15'd0, 16'h0});
    rd(8'hC8, d); chk("R9 unmapped read", d, 0);
    rd(8'hC0, d); chk("R9 R10 ch0 undisturbed", d, {1'b1, 15'd20, 16'd2});
    rd(8'hC4, d); chk("R10 ch1 cleared", d[14:0], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule